// File: doc/BRIEF.md
# Base Address Register Sizing Logic

This block holds the six base address registers and the expansion ROM address register of a configuration-space header. Firmware finds the size of each decode window by writing all ones and reading back which upper bits stuck, and then writes the real base address. The block stores each register with its low bits forced to the window's fixed type code. It also rejects writes to windows that are not implemented or whose type it does not support.

The size exponent and type of each window are parameters fixed at elaboration. Writes and reads are whole 32-bit dwords addressed by a byte offset. A read returns its data on the cycle after it is requested.

Top module: `bar_probe_regs`

## Requirements
- R1: After reset each register reads its type code: 0x0 for a 32-bit memory window, 0x1 for an I/O window, 0x4 for a window of the unsupported memory type (bits 2:1 = 2'b10), and 0x0 for the ROM register. `rdata` is 0.
- R2: A window whose size exponent is 0 ignores every write and always reads 0.
- R3: On a window register (offsets 0x10, 0x14, 0x18, 0x1C, 0x20, 0x24 map to index (offset − 0x10)/4), a write whose bits 31:4 are all ones is a size probe. The register then holds all ones above the size exponent, with the type code in the bits below it.
- R4: A write whose bits 31:4 equal 0x0000FFF is also a size probe, with the same result as R3. Bits 3:0 of a probe write are ignored.
- R5: Any other accepted write to a window stores the written data with the bits below the size exponent replaced by the type code.
- R6: An I/O window always reads bit 0 as 1. A nonzero exponent below the minimum is raised to it: 4 for memory windows, 2 for I/O windows, 11 for the ROM register.
- R7: On the ROM register at offset 0x30 (index 6), a write with bits 31:11 all ones is a size probe and stores only the size mask, with bit 0 clear. Any other write stores the data above the exponent together with bit 0, the enable bit.
- R8: A write with byte enables other than 4'b1111, or to an offset with bits 1:0 nonzero, changes no register.
- R9: A write to a window of the unsupported memory type leaves the register unchanged and pulses `type_err` high for exactly the cycle after the write.
- R10: `rdata` is loaded on the clock edge that samples `rd_en` and holds between reads. Offsets that do not name a register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Byte offset into configuration space |
| be | input | 4 | Byte enables of the write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| type_err | output | 1 | Pulses after a write to an unsupported window type |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high together, and that `wdata` and `addr` are stable for the cycle that a strobe is high. The bench drives every access on the falling clock edge and raises only one strobe per access, so both assumptions hold. The probe and type-code properties hold only for accepted full-dword writes. The stimulus therefore mixes accepted writes with partial, misaligned and rejected ones, so that the hold properties are exercised as well.

// File: rtl/bar_pkg.sv
// Shared types and helpers for the base address register block.
// Assumes 32-bit registers and at most seven register slots.
package bar_pkg;

    typedef enum logic [1:0] {
        KIND_MEM32 = 2'd0,
        KIND_IO    = 2'd1,
        KIND_MEM64 = 2'd2
    } bar_kind_e;

    localparam int unsigned NUM_WIN   = 6;
    localparam int unsigned NUM_SLOT  = NUM_WIN + 1;
    localparam int unsigned ROM_SLOT  = 6;
    localparam int unsigned SLOT_W    = $clog2(NUM_SLOT);
    localparam int unsigned MIN_MEM   = 4;
    localparam int unsigned MIN_IO    = 2;
    localparam int unsigned MIN_ROM   = 11;

    // Fixed low-bit code that a window of the given kind always reads back.
    function automatic logic [31:0] kind_code(input logic [1:0] k);
        case (k)
            2'd1:    return 32'h1;
            2'd2:    return 32'h4;
            default: return 32'h0;
        endcase
    endfunction

    // Raise a nonzero exponent to the minimum allowed for its kind; cap at 31.
    function automatic int unsigned eff_exp(input int unsigned e, input logic [1:0] k,
                                            input logic is_rom);
        int unsigned lo;
        lo = is_rom ? MIN_ROM : ((k == 2'd1) ? MIN_IO : MIN_MEM);
        if (e == 0) return 0;
        if (e < lo) return lo;
        if (e > 31) return 31;
        return e;
    endfunction

endpackage

// File: rtl/bar_decode.sv
// Turns a byte offset into a register slot index.
// Assumes slots sit at 0x10..0x24 in dword steps plus the ROM slot at 0x30.
module bar_decode
    import bar_pkg::*;
#(
    parameter int unsigned AW      = 8,
    parameter int unsigned WIN_LO  = 'h10,
    parameter int unsigned ROM_OFF = 'h30
) (
    input  logic [AW-1:0]     addr,
    input  logic [3:0]        be,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              slot_hit,
    output logic              full_dword
);
    localparam int unsigned WIN_HI = WIN_LO + 4 * (NUM_WIN - 1);

    logic [AW-1:0] rel;

    // Offset relative to the first window and the resulting slot match.
    always_comb begin
        rel        = addr - AW'(WIN_LO);
        full_dword = (be == 4'hF) && (addr[1:0] == 2'b00);
        slot_hit   = 1'b0;
        slot_idx   = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr >= AW'(WIN_LO) && addr <= AW'(WIN_HI)) begin
                slot_hit = 1'b1;
                slot_idx = rel[SLOT_W+1:2];
            end else if (addr == AW'(ROM_OFF)) begin
                slot_hit = 1'b1;
                slot_idx = SLOT_W'(ROM_SLOT);
            end
        end
    end

endmodule

// File: rtl/bar_slot.sv
// One base address register. A generate choice picks the variant: an empty
// window (exponent 0), a ROM register, or an ordinary window.
// Assumes wr_stb is already qualified by address match and a full dword.
module bar_slot
    import bar_pkg::*;
#(
    parameter int unsigned EXP    = 12,
    parameter logic [1:0]  KIND   = 2'd0,
    parameter bit          IS_ROM = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb,
    input  logic [31:0] wdata,
    output logic [31:0] value,
    output logic        rej
);
    localparam int unsigned E     = eff_exp(EXP, KIND, IS_ROM);
    localparam logic [31:0] MASK  = ~((32'd1 << E) - 32'd1);
    localparam logic [31:0] TCODE = IS_ROM ? 32'h0 : kind_code(KIND);
    localparam bit          UNSUP = !IS_ROM && (KIND == KIND_MEM64);

    generate
        if (E == 0) begin : g_empty
            logic unused_in;
            assign unused_in = ^{wr_stb, wdata};
            assign rej       = 1'b0;

            // Unimplemented window: register stays cleared.
            always_ff @(posedge clk) begin
                value <= 32'h0;
            end

            // R2
            empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_stb |=> (value == 32'h0));

        end else if (IS_ROM) begin : g_rom
            logic probe;
            assign probe = &wdata[31:11];
            assign rej   = 1'b0;

            // ROM register: size probe or base plus enable bit.
            always_ff @(posedge clk) begin
                if (!rst_n)      value <= 32'h0;
                else if (wr_stb) value <= probe ? MASK
                                                : ((wdata & MASK) | {31'h0, wdata[0]});
            end

            // R7
            rom_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_stb && probe) |=> (value == MASK));

            // R7
            rom_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (value[E-1:1] == '0));

        end else begin : g_win
            logic probe;
            assign probe = (wdata[31:4] == 28'hFFF_FFFF) || (wdata[31:4] == 28'h000_0FFF);
            assign rej   = wr_stb && UNSUP;

            // Window register: probe mask or masked base, type code kept.
            always_ff @(posedge clk) begin
                if (!rst_n)               value <= TCODE;
                else if (wr_stb && !UNSUP) value <= probe ? (MASK | TCODE)
                                                          : ((wdata & MASK) | TCODE);
            end

            // R6
            type_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((value & ~MASK) == TCODE));

            // R3
            probe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_stb && probe && !UNSUP) |=> ((value & MASK) == MASK));

            // R9
            unsup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_stb && UNSUP) |=> $stable(value));
        end
    endgenerate

endmodule

// File: rtl/bar_read_mux.sv
// Registered read path selecting one slot value, zero on a miss.
// Assumes idx is meaningful only while hit is high.
module bar_read_mux
    import bar_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_stb,
    input  logic                      hit,
    input  logic [SLOT_W-1:0]         idx,
    input  logic [NUM_SLOT-1:0][31:0] vals,
    output logic [31:0]               rdata
);
    // Capture the selected slot on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= 32'h0;
        else if (rd_stb) rdata <= hit ? vals[idx] : 32'h0;
    end

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rdata));

endmodule

// File: rtl/bar_probe_regs.sv
// Base address registers of a configuration header: six windows and a ROM
// register with probe handling and write rejection.
// Assumes wr_en and rd_en are single-cycle strobes that are never high together.
module bar_probe_regs
    import bar_pkg::*;
#(
    parameter int unsigned          AW       = 8,
    parameter logic [6:0][5:0]      SLOT_EXP = {6'd16, 6'd8, 6'd8, 6'd2, 6'd0, 6'd5, 6'd12},
    parameter logic [5:0][1:0]      WIN_KIND = {2'd2, 2'd1, 2'd0, 2'd0, 2'd1, 2'd0}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [3:0]    be,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          type_err
);
    logic [SLOT_W-1:0]         idx;
    logic                      hit;
    logic                      full;
    logic [NUM_SLOT-1:0][31:0] vals;
    logic [NUM_SLOT-1:0]       rej;

    bar_decode #(.AW(AW)) i_dec (
        .addr       (addr),
        .be         (be),
        .slot_idx   (idx),
        .slot_hit   (hit),
        .full_dword (full)
    );

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        localparam bit         ROM = (s == ROM_SLOT);
        localparam logic [1:0] K   = ROM ? 2'd0 : WIN_KIND[(s < NUM_WIN) ? s : 0];
        logic stb;
        assign stb = wr_en && hit && full && (idx == SLOT_W'(s));

        bar_slot #(.EXP(int'(SLOT_EXP[s])), .KIND(K), .IS_ROM(ROM)) i_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_stb (stb),
            .wdata  (wdata),
            .value  (vals[s]),
            .rej    (rej[s])
        );
    end

    // Error pulse one cycle after a rejected write.
    always_ff @(posedge clk) begin
        if (!rst_n) type_err <= 1'b0;
        else        type_err <= |rej;
    end

    bar_read_mux i_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_stb (rd_en),
        .hit    (hit),
        .idx    (idx),
        .vals   (vals),
        .rdata  (rdata)
    );

    // R8
    partial_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full) |=> $stable(vals));

    // R9
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        type_err |-> $past(wr_en));

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (type_err && !wr_en) |=> !type_err);

endmodule

// File: tb/test_bar_probe_regs.sv
module test_bar_probe_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        type_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bar_probe_regs i_bar_probe_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .be(be), .wdata(wdata), .rdata(rdata), .type_err(type_err)
    );

    // {waddr, be, wdata, raddr, expected read, expected type_err}
    localparam int NV = 20;
    localparam logic [84:0] VEC [NV] = '{
        {8'h10, 4'hF, 32'hFFFFFFFF, 8'h10, 32'hFFFFF000, 1'b0}, // R3
        {8'h10, 4'hF, 32'hABCD1234, 8'h10, 32'hABCD1000, 1'b0}, // R5
        {8'h10, 4'hF, 32'h0000FFF5, 8'h10, 32'hFFFFF000, 1'b0}, // R4
        {8'h10, 4'hF, 32'h0000FFE0, 8'h10, 32'h0000F000, 1'b0}, // R5
        {8'h14, 4'hF, 32'hFFFFFFFF, 8'h14, 32'hFFFFFFE1, 1'b0}, // R6 io probe
        {8'h14, 4'hF, 32'h0000C0F0, 8'h14, 32'h0000C0E1, 1'b0}, // R6
        {8'h18, 4'hF, 32'hFFFFFFFF, 8'h18, 32'h00000000, 1'b0}, // R2
        {8'h18, 4'hF, 32'h12345678, 8'h18, 32'h00000000, 1'b0}, // R2
        {8'h1C, 4'hF, 32'hFFFFFFF0, 8'h1C, 32'hFFFFFFF0, 1'b0}, // R6 clamp
        {8'h1C, 4'hF, 32'h12345678, 8'h1C, 32'h12345670, 1'b0}, // R6
        {8'h20, 4'hF, 32'hFFFFFFFF, 8'h20, 32'hFFFFFF01, 1'b0}, // R3
        {8'h20, 4'hF, 32'h0000FFF0, 8'h20, 32'hFFFFFF01, 1'b0}, // R4
        {8'h24, 4'hF, 32'hFFFFFFFF, 8'h24, 32'h00000004, 1'b1}, // R9
        {8'h30, 4'hF, 32'hFFFFF800, 8'h30, 32'hFFFF0000, 1'b0}, // R7
        {8'h30, 4'hF, 32'h000C8001, 8'h30, 32'h000C0001, 1'b0}, // R7
        {8'h30, 4'hF, 32'hFFFFF801, 8'h30, 32'hFFFF0000, 1'b0}, // R7
        {8'h10, 4'h3, 32'h00000000, 8'h10, 32'h0000F000, 1'b0}, // R8
        {8'h11, 4'hF, 32'h00000000, 8'h10, 32'h0000F000, 1'b0}, // R8
        {8'h10, 4'h0, 32'h11111111, 8'h28, 32'h00000000, 1'b0}, // R10
        {8'h00, 4'hF, 32'h22222222, 8'h00, 32'h00000000, 1'b0}  // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; be = b; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; be = 4'h0;
    endtask

    task automatic do_read(input logic [7:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h0, 32'h1);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rdata", rdata, 32'h0);
        check("R1 type_err", {31'h0, type_err}, 32'h0);
        do_read(8'h10); check("R1 bar0", rdata, 32'h0);
        do_read(8'h14); check("R1 bar1", rdata, 32'h1);
        do_read(8'h18); check("R1 bar2", rdata, 32'h0);
        do_read(8'h20); check("R1 bar4", rdata, 32'h1);
        do_read(8'h24); check("R1 bar5", rdata, 32'h4);
        do_read(8'h30); check("R1 rom", rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [84:0] v;
            v = VEC[i];
            do_write(v[84:77], v[76:73], v[72:41]);
            check($sformatf("vec%0d type_err R9", i), {31'h0, type_err}, {31'h0, v[0]});
            do_read(v[40:33]);
            check($sformatf("vec%0d read", i), rdata, v[32:1]);
        end

        // R9: the error pulse lasts exactly one cycle
        do_write(8'h24, 4'hF, 32'h12345678);
        check("R9 pulse", {31'h0, type_err}, 32'h1);
        @(negedge clk);
        check("R9 pulse end", {31'h0, type_err}, 32'h0);

        // R10: rdata holds while no read is requested
        do_read(8'h14);
        do_write(8'h14, 4'hF, 32'h0000A000);
        @(negedge clk);
        check("R10 hold", rdata, 32'h0000C0E1);

        // R1: a second reset restores the type codes
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 rdata after reset", rdata, 32'h0);
        do_read(8'h14); check("R1 bar1 after reset", rdata, 32'h1);
        do_read(8'h10); check("R1 bar0 after reset", rdata, 32'h0);

        done = 1'b1;
        summary();
    end

endmodule